// File: doc/BRIEF.md
# Shadowed Match-Register PWM Generator

This block produces six pulse-width-modulated outputs from one shared up-counter and seven match registers. Match register 0 fixes the cycle length: when the count reaches that value it returns to zero on the next tick. Registers 1 to 6 place edges. A channel in single-edge mode is high from the start of each cycle until the count reaches its own register. A channel in double-edge mode is switched on by one register and off by the next one, so its pulse can sit anywhere in the cycle. This allows several non-overlapping, phase-shifted pulses, such as those needed for three-phase motor drive.

A prescaler divides the system clock before it reaches the counter. Software writes new match values into shadow copies. It then arms a per-register latch bit, and the shadow value moves into the active register only when the cycle wraps, so a cycle never mixes old and new settings. Each match produces a one-cycle event pulse that can serve as an interrupt request.

Top module: `pwm_match_gen`

## Requirements
- R1: With run enabled, the count goes 0,1,...,A0 and then returns to 0, where A0 is active register 0. A cycle lasts A0+1 ticks and the count never exceeds A0.
- R2: A tick happens once every prescale+1 clock cycles. Between ticks the count does not change.
- R3: A write with index 0 to 6 stores into that register's shadow copy. An index of 7 is ignored. A pulse on latch bit k arms register k. At the tick where the count wraps, every armed register takes its shadow value and is disarmed. A latch pulse in that same cycle stays armed for the next wrap. An active register changes at no other time.
- R4: In single-edge mode (mode bit 0), channel n is high while the count is below active register n.
- R5: In single-edge mode, an active value of 0 keeps the channel low for the whole cycle. A value above A0 keeps it high for the whole cycle.
- R6: In double-edge mode (mode bit 1), channel n goes high when the count reaches active register n-1 and low when it reaches active register n. It holds its level otherwise. If both registers are equal, the output stays low.
- R7: The event bit for register k is high for exactly the one clock cycle that follows a tick on which the count became equal to active register k.
- R8: While run is low, the prescaler and count are held at zero and all outputs and events are low from the next cycle on. Outputs are also low after reset.
- R9: When a channel's enable is low, its output is low from the next cycle on, and its double-edge state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter run enable |
| prescale | input | PRE_W | Clock cycles per tick, minus one |
| wr_en | input | 1 | Shadow register write strobe |
| wr_idx | input | 3 | Shadow register index (0..6) |
| wr_data | input | CNT_W | Value to write |
| latch_req | input | 7 | Per-register arm pulse for wrap transfer |
| ch_en | input | 6 | Per-channel output enable (bit 0 = channel 1) |
| ch_dbl | input | 6 | Per-channel mode: 0 single-edge, 1 double-edge |
| pwm_out | output | 6 | Registered PWM outputs (bit 0 = channel 1) |
| match_evt | output | 7 | One-cycle match event pulses per register |

## Verification
Outputs and events are registered. Each result therefore appears in the clock cycle that follows the edge where its tick, wrap or input change was sampled. Prescaler ticks, shadow-to-active transfers and enable changes all take effect at that same single edge. The bench drives every input on the falling edge and advances a behavioural model on the rising edge. It compares all outputs on the next falling edge, so each expectation is checked in exactly the cycle the one-register delay puts it in. Directed phases cover several prescale values, deferred shadow loads, both edge modes, the zero and beyond-period corners, and disabling the block while it is running.

// File: rtl/pwm_match_pkg.sv
package pwm_match_pkg;
    localparam int NMATCH = 7;
    localparam int NCH    = NMATCH - 1;
    localparam int IDX_W  = $clog2(NMATCH);
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] pc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run_en && (st_q.pc >= prescale);
        if (!run_en)   st_d.pc = '0;
        else if (tick) st_d.pc = '0;
        else           st_d.pc = st_q.pc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: with a nonzero divider, two ticks never come back to back
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && prescale != '0) |=> (!tick || prescale == '0));
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
    parameter int CNT_W  = 16,
    parameter int NMATCH = 7,
    parameter int IDX_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [CNT_W-1:0]             wr_data,
    input  logic [NMATCH-1:0]            latch_req,
    input  logic                         load,
    output logic [NMATCH-1:0][CNT_W-1:0] act_cur,
    output logic [NMATCH-1:0][CNT_W-1:0] act_nxt
);
    typedef struct packed {
        logic [NMATCH-1:0][CNT_W-1:0] shd;
        logic [NMATCH-1:0][CNT_W-1:0] act;
        logic [NMATCH-1:0]            pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NMATCH; k++) begin
            if (load && st_q.pend[k]) st_d.act[k] = st_q.shd[k];
        end
        st_d.pend = (load ? '0 : st_q.pend) | latch_req;
        if (wr_en && (int'(wr_idx) < NMATCH)) st_d.shd[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_cur = st_q.act;
    assign act_nxt = st_d.act;

    // R3: active copies only move on a wrap
    assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_cur));
    // R3: a wrap disarms everything not re-armed in the same cycle
    assert_pend_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((st_q.pend & ~$past(latch_req)) == '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             ch_en,
    input  logic             dbl,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] m_set,
    input  logic [CNT_W-1:0] m_clr,
    output logic             pwm
);
    typedef struct packed {
        logic lvl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_en || !ch_en) begin
            st_d.lvl = 1'b0;
        end else if (tick) begin
            if (dbl) begin
                if (cnt_nxt == m_clr)      st_d.lvl = 1'b0;
                else if (cnt_nxt == m_set) st_d.lvl = 1'b1;
            end else begin
                st_d.lvl = (cnt_nxt < m_clr);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm = st_q.lvl;

    assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !pwm);
    assert_chan_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> !pwm);
    // R5: a zero edge in single mode never lets the output rise
    assert_zero_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dbl && m_clr == '0) |=> !pwm);
endmodule

// File: rtl/pwm_match_gen.sv
module pwm_match_gen
    import pwm_match_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [PRE_W-1:0] prescale,
    input  logic             wr_en,
    input  logic [2:0]       wr_idx,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [6:0]       latch_req,
    input  logic [5:0]       ch_en,
    input  logic [5:0]       ch_dbl,
    output logic [5:0]       pwm_out,
    output logic [6:0]       match_evt
);
    typedef struct packed {
        logic [CNT_W-1:0]  tc;
        logic [NMATCH-1:0] evt;
    } st_t;

    st_t  st_d, st_q;
    logic tick;
    logic wrap;
    logic [NMATCH-1:0][CNT_W-1:0] act_cur;
    logic [NMATCH-1:0][CNT_W-1:0] act_nxt;

    pwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .prescale(prescale), .tick(tick)
    );

    assign wrap = tick && (st_q.tc == act_cur[0]);

    pwm_match_bank #(.CNT_W(CNT_W), .NMATCH(NMATCH), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .latch_req(latch_req), .load(wrap),
        .act_cur(act_cur), .act_nxt(act_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (!run_en)   st_d.tc = '0;
        else if (wrap) st_d.tc = '0;
        else if (tick) st_d.tc = st_q.tc + 1'b1;
        for (int k = 0; k < NMATCH; k++) begin
            st_d.evt[k] = tick && (st_d.tc == act_nxt[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match_evt = st_q.evt;

    for (genvar n = 1; n <= NCH; n++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .run_en(run_en),
            .ch_en(ch_en[n-1]), .dbl(ch_dbl[n-1]), .tick(tick),
            .cnt_nxt(st_d.tc), .m_set(act_nxt[n-1]), .m_clr(act_nxt[n]),
            .pwm(pwm_out[n-1])
        );
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tc <= act_cur[0]);
    assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (st_q.tc == '0));
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !tick) |=> $stable(st_q.tc));
    assert_evt_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt[0] |-> (st_q.tc == act_cur[0]));
endmodule

// File: tb/tb_pwm_match_gen.sv
module tb_pwm_match_gen;
    localparam int CW = 16;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic [PW-1:0] prescale = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_idx = '0;
    logic [CW-1:0] wr_data = '0;
    logic [6:0]    latch_req = '0;
    logic [5:0]    ch_en = '0;
    logic [5:0]    ch_dbl = '0;
    logic [5:0]    pwm_out;
    logic [6:0]    match_evt;

    pwm_match_gen #(.CNT_W(CW), .PRE_W(PW)) dut (.*);

    always #5 clk = ~clk;

    // behavioural reference
    int       m_pc, m_tc;
    int       m_act[7];
    int       m_shd[7];
    bit [6:0] m_pend;
    logic [5:0] exp_out = '0;
    logic [6:0] exp_evt = '0;

    int    vectors = 0;
    int    errors = 0;
    bit    checking = 1'b0;
    string cur_req = "R8";

    initial begin
        m_pc = 0; m_tc = 0; m_pend = '0;
        foreach (m_act[k]) begin m_act[k] = 0; m_shd[k] = 0; end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            bit tk, wr;
            int nt;
            tk = run_en && (m_pc >= int'(prescale));
            wr = tk && (m_tc == m_act[0]);
            m_pc = !run_en ? 0 : (tk ? 0 : m_pc + 1);
            if (wr) begin
                for (int k = 0; k < 7; k++) if (m_pend[k]) m_act[k] = m_shd[k];
                m_pend = '0;
            end
            m_pend |= latch_req;
            if (wr_en && wr_idx != 3'd7) m_shd[wr_idx] = int'(wr_data);
            if (!run_en) nt = 0;
            else if (wr) nt = 0;
            else if (tk) nt = m_tc + 1;
            else nt = m_tc;
            m_tc = nt;
            for (int k = 0; k < 7; k++) exp_evt[k] = tk && (nt == m_act[k]);
            for (int n = 1; n <= 6; n++) begin
                if (!run_en || !ch_en[n-1]) exp_out[n-1] = 1'b0;
                else if (tk) begin
                    if (ch_dbl[n-1]) begin
                        if (nt == m_act[n]) exp_out[n-1] = 1'b0;
                        else if (nt == m_act[n-1]) exp_out[n-1] = 1'b1;
                    end else exp_out[n-1] = (nt < m_act[n]);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            vectors++;
            if (pwm_out !== exp_out || match_evt !== exp_evt) begin
                errors++;
                $display("FAIL %s t=%0t out=%b evt=%b expected out=%b evt=%b",
                         cur_req, $time, pwm_out, match_evt, exp_out, exp_evt);
            end
        end
    end

    task automatic wr_reg(input int idx, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_data = CW'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic arm(input logic [6:0] mask);
        @(negedge clk);
        latch_req = mask;
        @(negedge clk);
        latch_req = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired during %s", cur_req);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        idle(2);
        // R8: reset state
        vectors++;
        if (pwm_out !== '0 || match_evt !== '0) begin
            errors++;
            $display("FAIL R8 reset out=%b evt=%b expected 0", pwm_out, match_evt);
        end
        rst_n = 1'b1;
        checking = 1'b1;

        // R1 R4 R5: period 10 ticks, mixed single-edge widths, 0 and >period corners
        cur_req = "R1/R4/R5";
        wr_reg(0, 9); wr_reg(1, 3); wr_reg(2, 0); wr_reg(3, 12);
        wr_reg(4, 9); wr_reg(5, 5); wr_reg(6, 7);
        arm(7'h7f);
        ch_en = 6'h3f;
        run_en = 1'b1;
        idle(60);

        // R6: double-edge channels, including equal set/clear on channel 6
        cur_req = "R6";
        wr_reg(4, 2); wr_reg(5, 6); wr_reg(6, 6);
        arm(7'h70);
        ch_dbl = 6'b110010;
        idle(60);

        // R6 R7: channel 1 double-edge rising on the period register
        cur_req = "R6/R7";
        ch_dbl = 6'b110011;
        idle(40);

        // R2: prescaled ticks
        cur_req = "R2";
        prescale = 8'd3;
        idle(120);
        prescale = 8'd0;

        // R3: shadow writes without arming must not take effect, index 7 ignored
        cur_req = "R3";
        wr_reg(1, 8); wr_reg(5, 1);
        @(negedge clk); wr_en = 1'b1; wr_idx = 3'd7; wr_data = 16'd2;
        @(negedge clk); wr_en = 1'b0;
        idle(40);
        arm(7'h22);
        idle(40);
        // R3: shorten the period through the shadow path
        wr_reg(0, 4);
        arm(7'h01);
        idle(40);

        // R9: channel enables dropped and restored
        cur_req = "R9";
        ch_en = 6'b101010;
        idle(20);
        ch_en = 6'h3f;
        idle(30);

        // R8: stop and restart
        cur_req = "R8";
        run_en = 1'b0;
        idle(10);
        run_en = 1'b1;
        idle(30);

        checking = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule